// File: doc/BRIEF.md
# Guard-Timed SPI Host Engine

This block is the host end of a serial link to a slow peripheral. It uses SPI mode 0 (clock idles low, data sampled on the rising edge, most significant bit first). A client asks for a transaction by giving a byte count. It then supplies outgoing bytes one at a time through a valid/ready handshake and receives each incoming byte as a one-cycle strobe. The engine drives chip select, the serial clock and the outgoing data line, and it samples the incoming data line.

The peripheral cannot follow a continuous clock, so the engine adds long quiet periods. These occur after chip select falls, between bytes, before chip select rises, and while chip select stays high between transactions. Every period is a parameter counted in system-clock cycles. The defaults fit a 200 MHz clock: a 125 kHz bit clock, 65 µs lead, 40 µs byte gap, 100 µs trail and 50 µs minimum deselect time. A one-cycle completion pulse marks the point where the engine can accept new work.

Top module: `spi_guard_host`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, request-ready is high, and tx-ready, rx-valid and done are all low.
- R2: The serial clock is low whenever chip select is high. Within a byte, each high phase and each low phase lasts exactly HALF_CYC cycles.
- R3: Outgoing data goes out most significant bit first. Each bit is on the line before its rising clock edge and changes only after a falling edge.
- R4: Incoming data is captured on each rising clock edge, most significant bit first. After the eighth rising edge of a byte, rx-valid pulses for one cycle with the assembled byte on rx-data.
- R5: The first rising clock edge comes at least LEAD_CYC cycles after chip select falls.
- R6: Between the last falling edge of one byte and the first rising edge of the next, at least GAP_CYC cycles pass.
- R7: Chip select rises exactly TRAIL_CYC cycles after the last falling clock edge of the transaction.
- R8: Chip select stays high for at least HOLD_CYC cycles before it falls again. A request is taken only in a cycle where both request-valid and request-ready are high.
- R9: Done pulses for one cycle, exactly HOLD_CYC cycles after chip select rises. Request-ready is high from that cycle on.
- R10: A request with byte count N produces exactly N tx-ready handshakes, 8·N rising clock edges and N rx-valid pulses, all inside a single chip-select frame.
- R11: A byte count of zero still produces a complete chip-select frame and a done pulse, but no clock edge, no tx-ready and no rx-valid.
- R12: If an outgoing byte is late, the clock waits. No edge is produced until that byte has been handshaken, so the lead time or byte gap grows by at least the delay.
- R13: A request raised while the engine is busy has no effect. Request-ready stays low, and no second chip-select frame follows the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Transaction request |
| reqReady | output | 1 | Engine idle, request will be taken |
| reqLen | input | LEN_W | Number of bytes in the transaction |
| txValid | input | 1 | Outgoing byte available |
| txReady | output | 1 | Engine waiting for the next outgoing byte |
| txData | input | 8 | Outgoing byte |
| rxValid | output | 1 | One-cycle strobe for a received byte |
| rxData | output | 8 | Received byte |
| done | output | 1 | One-cycle transaction completion pulse |
| nss | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
A wrong sequencer state shows up at the pins within one guard period. A timer that is off shifts a chip-select or clock edge away from its expected cycle, and the edge-distance checks in the bench see this on that same transaction. A wrong bit or byte counter produces a transaction with the wrong number of clock edges or handshakes, or with bytes that are shifted or truncated. These errors appear on the data lines by the end of the first affected byte. A request taken while busy shows up as an extra chip-select frame right after the done pulse.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;

  typedef struct packed {
    logic selLow;   // drive chip select low
    logic selHigh;  // release chip select
    logic loadTx;   // capture the next outgoing byte
    logic clkRise;  // raise sck, sample miso
    logic clkFall;  // lower sck, advance mosi
    logic lastBit;  // qualifies clkRise: eighth bit of a byte
    logic finish;   // transaction complete
  } spiStrobes_t;

  function automatic int maxInt(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/spi_guard_ctrl.sv
module spi_guard_ctrl
  import spi_guard_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int HALF_CYC  = 800,
  parameter int LEAD_CYC  = 13000,
  parameter int GAP_CYC   = 8000,
  parameter int TRAIL_CYC = 20000,
  parameter int HOLD_CYC  = 10000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             txValid,
  output logic             reqReady,
  output logic             txReady,
  output spiStrobes_t      strb
);

  localparam int MAX_CYC = maxInt(maxInt(maxInt(HALF_CYC, LEAD_CYC), maxInt(GAP_CYC, TRAIL_CYC)), HOLD_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_FETCH, ST_LOW, ST_HIGH, ST_GAP, ST_TRAIL, ST_HOLD
  } phase_e;

  phase_e           state, stateNext;
  logic [CNT_W-1:0] timer, timerNext;
  logic [LEN_W-1:0] remain, remainNext;
  logic [2:0]       bitIdx, bitIdxNext;

  always_comb begin
    stateNext  = state;
    timerNext  = (timer != '0) ? timer - 1'b1 : timer;
    remainNext = remain;
    bitIdxNext = bitIdx;
    strb       = '0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strb.selLow = 1'b1;
        remainNext  = reqLen;
        timerNext   = CNT_W'(LEAD_CYC - 1);
        stateNext   = ST_LEAD;
      end
      ST_LEAD: if (timer == '0) begin
        if (remain == '0) begin
          timerNext = CNT_W'(TRAIL_CYC - 1);
          stateNext = ST_TRAIL;
        end else begin
          stateNext = ST_FETCH;
        end
      end
      ST_GAP: if (timer == '0) stateNext = ST_FETCH;
      ST_FETCH: if (txValid) begin
        strb.loadTx = 1'b1;
        bitIdxNext  = '0;
        timerNext   = CNT_W'(HALF_CYC - 1);
        stateNext   = ST_LOW;
      end
      ST_LOW: if (timer == '0) begin
        strb.clkRise = 1'b1;
        strb.lastBit = (bitIdx == 3'd7);
        timerNext    = CNT_W'(HALF_CYC - 1);
        stateNext    = ST_HIGH;
      end
      ST_HIGH: if (timer == '0) begin
        strb.clkFall = 1'b1;
        if (bitIdx == 3'd7) begin
          remainNext = remain - 1'b1;
          if (remain == LEN_W'(1)) begin
            timerNext = CNT_W'(TRAIL_CYC - 1);
            stateNext = ST_TRAIL;
          end else begin
            timerNext = CNT_W'(GAP_CYC - 1);
            stateNext = ST_GAP;
          end
        end else begin
          bitIdxNext = bitIdx + 1'b1;
          timerNext  = CNT_W'(HALF_CYC - 1);
          stateNext  = ST_LOW;
        end
      end
      ST_TRAIL: if (timer == '0) begin
        strb.selHigh = 1'b1;
        timerNext    = CNT_W'(HOLD_CYC - 1);
        stateNext    = ST_HOLD;
      end
      ST_HOLD: if (timer == '0) begin
        strb.finish = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      remain <= '0;
      bitIdx <= '0;
    end else begin
      state  <= stateNext;
      timer  <= timerNext;
      remain <= remainNext;
      bitIdx <= bitIdxNext;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign txReady  = (state == ST_FETCH);

  // R8 / R13: once taken, the engine is busy on the next cycle
  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R10: a loaded byte closes the handshake window
  assert_tx_once_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);

endmodule

// File: rtl/spi_guard_datapath.sv
module spi_guard_datapath
  import spi_guard_pkg::*;
#(
  parameter int LEAD_CYC  = 13000,
  parameter int TRAIL_CYC = 20000
) (
  input  logic        clk,
  input  logic        rstN,
  input  spiStrobes_t strb,
  input  logic [7:0]  txData,
  input  logic        miso,
  output logic        nss,
  output logic        sck,
  output logic        mosi,
  output logic        rxValid,
  output logic [7:0]  rxData,
  output logic        done
);

  logic [7:0] txShift;
  logic [7:0] rxShift;
  logic [7:0] rxAssembled;

  assign rxAssembled = {rxShift[6:0], miso};
  assign mosi        = txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nss     <= 1'b1;
      sck     <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
      rxValid <= 1'b0;
      rxData  <= '0;
      done    <= 1'b0;
    end else begin
      if (strb.selLow)       nss <= 1'b0;
      else if (strb.selHigh) nss <= 1'b1;

      if (strb.clkRise)      sck <= 1'b1;
      else if (strb.clkFall) sck <= 1'b0;

      if (strb.loadTx)       txShift <= txData;
      else if (strb.clkFall) txShift <= {txShift[6:0], 1'b0};

      if (strb.clkRise) rxShift <= rxAssembled;
      rxValid <= strb.clkRise & strb.lastBit;
      if (strb.clkRise & strb.lastBit) rxData <= rxAssembled;

      done <= strb.finish;
    end
  end

  // Independent edge-distance monitors for the guard assertions
  localparam int AGE_W = $clog2(maxInt(LEAD_CYC, TRAIL_CYC) + 2);
  logic [AGE_W-1:0] selAge;
  logic [AGE_W-1:0] fallAge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selAge  <= '0;
      fallAge <= '1;
    end else begin
      if (nss)                selAge <= '0;
      else if (selAge != '1)  selAge <= selAge + 1'b1;
      if (sck)                fallAge <= '0;
      else if (fallAge != '1) fallAge <= fallAge + 1'b1;
    end
  end

  assert_sck_in_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !nss);

  assert_mosi_steady_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

  assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_lead_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> (32'(selAge) >= LEAD_CYC));

  assert_trail_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nss) |-> (32'(fallAge) >= TRAIL_CYC));

  assert_done_deselected_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (nss && !sck));

endmodule

// File: rtl/spi_guard_host.sv
module spi_guard_host
  import spi_guard_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int HALF_CYC  = 800,
  parameter int LEAD_CYC  = 13000,
  parameter int GAP_CYC   = 8000,
  parameter int TRAIL_CYC = 20000,
  parameter int HOLD_CYC  = 10000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             txValid,
  output logic             txReady,
  input  logic [7:0]       txData,
  output logic             rxValid,
  output logic [7:0]       rxData,
  output logic             done,
  output logic             nss,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);

  spiStrobes_t strb;

  spi_guard_ctrl #(
    .LEN_W(LEN_W), .HALF_CYC(HALF_CYC), .LEAD_CYC(LEAD_CYC),
    .GAP_CYC(GAP_CYC), .TRAIL_CYC(TRAIL_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .txValid(txValid), .reqReady(reqReady), .txReady(txReady), .strb(strb)
  );

  spi_guard_datapath #(
    .LEAD_CYC(LEAD_CYC), .TRAIL_CYC(TRAIL_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData), .miso(miso),
    .nss(nss), .sck(sck), .mosi(mosi), .rxValid(rxValid), .rxData(rxData),
    .done(done)
  );

endmodule

// File: tb/spi_guard_host_tb.sv
module spi_guard_host_tb;

  localparam int LEN_W = 4;
  localparam int HALF  = 4;
  localparam int LEAD  = 20;
  localparam int GAP   = 12;
  localparam int TRAIL = 24;
  localparam int HOLD  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [LEN_W-1:0] reqLen = '0;
  logic txValid = 1'b0;
  logic [7:0] txData = '0;
  logic miso = 1'b0;
  logic reqReady, txReady, rxValid, done, nss, sck, mosi;
  logic [7:0] rxData;

  always #2.5 clk = ~clk;

  spi_guard_host #(
    .LEN_W(LEN_W), .HALF_CYC(HALF), .LEAD_CYC(LEAD), .GAP_CYC(GAP),
    .TRAIL_CYC(TRAIL), .HOLD_CYC(HOLD)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqLen(reqLen), .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxData(rxData), .done(done), .nss(nss), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- port monitor and peripheral model ----------------
  logic [7:0] txb [16];
  logic [7:0] slv [16];
  logic [7:0] mosiArr [16];
  logic [7:0] rxBuf [16];
  int sinceSel = 0, sinceFall = 1000000, highCnt = 1000000, phaseCnt = 0;
  int rises, frames, dones, rxN, txHs, phaseErr;
  int leadMeas, gapMin, trailMeas, holdMeas, doneDelay;
  int sIdx = 0, sBit = 0;
  logic [7:0] sShift = '0;
  logic pNss = 1'b1, pSck = 1'b0;

  task automatic clrMon();
    rises = 0; frames = 0; dones = 0; rxN = 0; txHs = 0; phaseErr = 0;
    leadMeas = -1; gapMin = 1000000; trailMeas = -1; doneDelay = -1;
    for (int i = 0; i < 16; i++) mosiArr[i] = '0;
  endtask

  always @(negedge clk) begin
    sinceSel++; sinceFall++; highCnt++; phaseCnt++;
    if (!nss && pNss) begin
      holdMeas = highCnt; sinceSel = 0; frames++;
      sIdx = 0; sBit = 0; sShift = slv[0]; miso = sShift[7];
    end
    if (nss && !pNss) begin
      highCnt = 0;
      if (rises > 0) trailMeas = sinceFall;
    end
    if (sck && !pSck) begin
      if (rises == 0) leadMeas = sinceSel;
      else if (rises % 8 == 0) begin
        if (sinceFall < gapMin) gapMin = sinceFall;
      end else if (phaseCnt != HALF) phaseErr++;
      mosiArr[(rises >> 3) & 15] = {mosiArr[(rises >> 3) & 15][6:0], mosi};
      rises++; phaseCnt = 0;
    end
    if (!sck && pSck) begin
      if (phaseCnt != HALF) phaseErr++;
      sinceFall = 0; phaseCnt = 0;
      sBit++;
      if (sBit == 8) begin
        sBit = 0; sIdx++; sShift = slv[sIdx & 15];
      end else sShift = {sShift[6:0], 1'b0};
      miso = sShift[7];
    end
    if (done) begin dones++; doneDelay = highCnt; end
    if (rxValid) begin rxBuf[rxN & 15] = rxData; rxN++; end
    if (txValid && txReady) txHs++;
    pNss = nss; pSck = sck;
  end

  // ---------------- drivers ----------------
  task automatic startReq(int n);
    @(negedge clk); reqValid = 1'b1; reqLen = LEN_W'(n);
    while (!reqReady) @(negedge clk);
    @(negedge clk); reqValid = 1'b0;
  endtask

  task automatic feedTx(int n, int dly);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!txReady) @(negedge clk);
      for (int d = 0; d < dly; d++) @(negedge clk);
      txValid = 1'b1; txData = txb[i];
      @(negedge clk);
      txValid = 1'b0;
    end
  endtask

  task automatic waitDone(int n);
    while (dones < n) @(negedge clk);
  endtask

  task automatic runTx(int n, int dly);
    clrMon();
    fork
      startReq(n);
      feedTx(n, dly);
    join
    waitDone(1);
  endtask

  task automatic chkBytes(int n, string tag);
    for (int i = 0; i < n; i++) begin
      chk(mosiArr[i] == txb[i], "R3", {tag, " mosi byte"}, int'(mosiArr[i]), int'(txb[i]));
      chk(rxBuf[i] == slv[i], "R4", {tag, " rx byte"}, int'(rxBuf[i]), int'(slv[i]));
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    chk(nss == 1'b1, "R1", "nss", int'(nss), 1);
    chk(sck == 1'b0, "R1", "sck", int'(sck), 0);
    chk(reqReady == 1'b1, "R1", "reqReady", int'(reqReady), 1);
    chk({txReady, rxValid, done} == 3'b000, "R1", "txReady/rxValid/done",
        int'({txReady, rxValid, done}), 0);
  endtask

  task automatic testSingle();
    txb[0] = 8'hA5; slv[0] = 8'h3C;
    runTx(1, 0);
    chkBytes(1, "single");
    chk(rises == 8, "R10", "single rises", rises, 8);
    chk(rxN == 1 && txHs == 1, "R10", "single rx+hs", rxN * 10 + txHs, 11);
    chk(leadMeas >= LEAD && leadMeas <= LEAD + HALF + 2, "R5", "lead", leadMeas, LEAD);
    chk(trailMeas == TRAIL, "R7", "trail", trailMeas, TRAIL);
    chk(phaseErr == 0, "R2", "phase errors", phaseErr, 0);
    chk(doneDelay == HOLD, "R9", "done delay", doneDelay, HOLD);
    @(negedge clk);
    chk(reqReady == 1'b1 && done == 1'b0, "R9", "ready after done, pulse width",
        int'({reqReady, done}), 2);
  endtask

  task automatic testMulti();
    txb[0] = 8'h81; txb[1] = 8'h00; txb[2] = 8'hFF;
    slv[0] = 8'h5A; slv[1] = 8'hC3; slv[2] = 8'h01;
    runTx(3, 0);
    chkBytes(3, "multi");
    chk(rises == 24, "R10", "multi rises", rises, 24);
    chk(txHs == 3 && rxN == 3 && frames == 1, "R10", "multi hs/rx/frames",
        txHs * 100 + rxN * 10 + frames, 331);
    chk(gapMin >= GAP && gapMin <= GAP + HALF + 2, "R6", "gap", gapMin, GAP);
    chk(phaseErr == 0, "R2", "multi phase errors", phaseErr, 0);
  endtask

  task automatic testStall();
    txb[0] = 8'h6E; txb[1] = 8'h17; slv[0] = 8'hE1; slv[1] = 8'h7F;
    runTx(2, 30);
    chkBytes(2, "stall");
    chk(leadMeas >= LEAD + 30, "R12", "stalled lead", leadMeas, LEAD + 30);
    chk(gapMin >= GAP + 30, "R12", "stalled gap", gapMin, GAP + 30);
    chk(rises == 16, "R12", "stalled rises", rises, 16);
  endtask

  task automatic testZero();
    runTx(0, 0);
    chk(rises == 0 && txHs == 0 && rxN == 0, "R11", "zero edges/hs/rx",
        rises + txHs + rxN, 0);
    chk(frames == 1 && dones == 1, "R11", "zero frame+done", frames * 10 + dones, 11);
  endtask

  task automatic testBackToBack();
    txb[0] = 8'h42; slv[0] = 8'h99;
    runTx(1, 0);
    runTx(1, 0);
    chk(holdMeas >= HOLD, "R8", "deselect time", holdMeas, HOLD);
    chkBytes(1, "b2b");
  endtask

  task automatic testBusyReq();
    txb[0] = 8'hC0; slv[0] = 8'h0F;
    clrMon();
    fork
      startReq(1);
      feedTx(1, 0);
      begin
        while (rises < 2) @(negedge clk);
        reqValid = 1'b1; reqLen = LEN_W'(2);
        for (int i = 0; i < 5; i++) begin
          @(negedge clk);
          chk(reqReady == 1'b0, "R13", "ready while busy", int'(reqReady), 0);
        end
        reqValid = 1'b0;
      end
    join
    waitDone(1);
    for (int i = 0; i < 80; i++) @(negedge clk);
    chk(frames == 1 && rises == 8, "R13", "no extra frame", frames * 100 + rises, 108);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin txb[i] = '0; slv[i] = '0; rxBuf[i] = '0; end
    clrMon();
    holdMeas = -1;
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testSingle();
    testMulti();
    testStall();
    testZero();
    testBackToBack();
    testBusyReq();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule